// File: doc/BRIEF.md
# Residual Add and LeakyReLU Stream Stage

This stage sits behind each convolution of a quantised CNN pipeline. It takes the convolution result on stream A and, for layers with a skip connection, a saved earlier feature map on stream B. For a residual layer each element of A is added to the matching element of B with signed saturation; for a plain layer B is left untouched and the A element goes on unchanged. Either way, the value then passes a LeakyReLU whose negative slope is an arithmetic right shift, and leaves on a single output stream with valid/ready/last handshakes.

The residual choice comes from a control input sampled when the first element of a layer is accepted; it then stays fixed until the element carrying the last flag on A has been accepted. In residual mode A and B are consumed together in one cycle, and a disagreement of their last flags is recorded in a sticky error output. The output is registered, so results appear one cycle after acceptance at a rate of one per cycle.

Top module: `skip_relu_stage`

## Requirements
- R1: After reset y_valid_o and err_o are 0.
- R2: In pass mode (mode sampled as res_en_i = 0) the output element is act(a) and b_ready_o stays 0, so no B element is consumed.
- R3: In residual mode (res_en_i = 1) an A element is accepted only when b_valid_i is also 1, both are consumed in the same cycle, and the output is act(sat(a + b)).
- R4: The sum of two signed DATA_W values saturates to the range [-2^(DATA_W-1), 2^(DATA_W-1)-1] instead of wrapping (127 + 127 gives 127, -128 + -128 gives -128 for 8 bits).
- R5: The activation leaves non-negative values unchanged and maps a negative x to x >>> 3 (floor of x/8), e.g. -1 to -1, -9 to -2, -128 to -16.
- R6: y_last_o of an output element equals a_last_i of the A element it came from.
- R7: res_en_i is sampled with the first accepted element of a layer; changes after that have no effect until the element with a_last_i = 1 has been accepted.
- R8: When a residual-mode acceptance sees a_last_i different from b_last_i, err_o becomes 1 from the next cycle and stays 1 until reset.
- R9: While y_valid_o = 1 and y_ready_i = 0, y_data_o and y_last_o hold and a_ready_o is 0.
- R10: An element accepted in cycle k is on the output with y_valid_o = 1 in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_en_i | input | 1 | Residual mode request, sampled at layer start |
| a_data_i | input | DATA_W | Convolution result element, signed |
| a_last_i | input | 1 | Last element of the layer on A |
| a_valid_i | input | 1 | A element valid |
| a_ready_o | output | 1 | A element accepted this cycle when valid |
| b_data_i | input | DATA_W | Skip element, signed |
| b_last_i | input | 1 | Last element of the layer on B |
| b_valid_i | input | 1 | B element valid |
| b_ready_o | output | 1 | B element accepted this cycle when valid |
| y_data_o | output | DATA_W | Activated result, signed |
| y_last_o | output | 1 | Last element of the layer |
| y_valid_o | output | 1 | Output element valid |
| y_ready_i | input | 1 | Downstream ready |
| err_o | output | 1 | Sticky last-flag mismatch in residual mode |

## Verification
The properties take for granted that the last flag of A marks layer ends and that res_en_i is only meant to act at a layer start; they make no demand that producers hold data while waiting, since the stage only samples on acceptance. The stimulus keeps within this by generating whole layers with one last flag each, holding res_en_i at the intended mode until the first element is taken and then toggling it at random to show it is ignored. Random valid and ready gaps on all three streams exercise stalls, and directed layers cover saturation extremes, rounding of negative shifts and a deliberate last-flag mismatch.

// File: rtl/skip_relu_pkg.sv
`timescale 1ns/1ps
package skip_relu_pkg;
  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_ADD  = 1'b1
  } mode_e;
endpackage

// File: rtl/skip_mode_ctl.sv
`timescale 1ns/1ps
module skip_mode_ctl
  import skip_relu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  res_en_i,
  input  logic  fire_i,
  input  logic  last_i,
  output mode_e mode_o
);
  logic  start_q;
  mode_e mode_q;

  // at a layer start the request is live; afterwards the latched copy rules
  assign mode_o = start_q ? mode_e'(res_en_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      mode_q  <= MODE_PASS;
    end else if (fire_i) begin
      start_q <= last_i;
      if (start_q) mode_q <= mode_e'(res_en_i);
    end
  end

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && !(fire_i && last_i)) |=> $stable(mode_o));
endmodule

// File: rtl/skip_sat_add.sv
`timescale 1ns/1ps
module skip_sat_add #(
  parameter int DATA_W = 8
) (
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] sum_w;
  logic signed [DATA_W-1:0] sat_w;

  assign sum_w = {a_i[DATA_W-1], a_i} + {b_i[DATA_W-1], b_i};

  always_comb begin
    if (sum_w[DATA_W] != sum_w[DATA_W-1]) sat_w = sum_w[DATA_W] ? MIN_V : MAX_V;
    else                                 sat_w = sum_w[DATA_W-1:0];
  end

  assign y_o = en_i ? sat_w : a_i;
endmodule

// File: rtl/skip_leaky.sv
`timescale 1ns/1ps
module skip_leaky #(
  parameter int DATA_W = 8,
  parameter int SHIFT  = 3
) (
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o
);
  logic signed [DATA_W-1:0] neg_w;

  assign neg_w = x_i >>> SHIFT;  // floor toward -inf
  assign y_o   = x_i[DATA_W-1] ? neg_w : x_i;
endmodule

// File: rtl/skip_out_reg.sv
`timescale 1ns/1ps
module skip_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              free_o,
  output logic [DATA_W-1:0] y_data_o,
  output logic              y_last_o,
  output logic              y_valid_o,
  input  logic              y_ready_i
);
  assign free_o = !y_valid_o || y_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_valid_o <= 1'b0;
      y_data_o  <= '0;
      y_last_o  <= 1'b0;
    end else if (free_o) begin
      y_valid_o <= in_valid_i;
      if (in_valid_i) begin
        y_data_o <= in_data_i;
        y_last_o <= in_last_i;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i) |=> (y_valid_o && $stable(y_data_o) && $stable(y_last_o)));
  p_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && free_o) |=> y_valid_o);
endmodule

// File: rtl/skip_relu_stage.sv
`timescale 1ns/1ps
module skip_relu_stage
  import skip_relu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SHIFT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_en_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_last_i,
  input  logic              a_valid_i,
  output logic              a_ready_o,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_last_i,
  input  logic              b_valid_i,
  output logic              b_ready_o,
  output logic [DATA_W-1:0] y_data_o,
  output logic              y_last_o,
  output logic              y_valid_o,
  input  logic              y_ready_i,
  output logic              err_o
);
  mode_e mode;
  logic  add_en, out_free, a_fire, b_fire;
  logic signed [DATA_W-1:0] sum_w, act_w;

  skip_mode_ctl u_mode (
    .clk_i, .rst_ni, .res_en_i,
    .fire_i (a_fire),
    .last_i (a_last_i),
    .mode_o (mode)
  );

  assign add_en    = (mode == MODE_ADD);
  assign a_ready_o = out_free && (!add_en || b_valid_i);
  assign b_ready_o = out_free && add_en && a_valid_i;
  assign a_fire    = a_valid_i && a_ready_o;
  assign b_fire    = b_valid_i && b_ready_o;

  skip_sat_add #(.DATA_W(DATA_W)) u_add (
    .en_i (add_en),
    .a_i  (a_data_i),
    .b_i  (b_data_i),
    .y_o  (sum_w)
  );

  skip_leaky #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_act (
    .x_i (sum_w),
    .y_o (act_w)
  );

  skip_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .in_valid_i (a_fire),
    .in_data_i  (act_w),
    .in_last_i  (a_last_i),
    .free_o     (out_free),
    .y_data_o, .y_last_o, .y_valid_o, .y_ready_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        err_o <= 1'b0;
    else if (a_fire && add_en && (a_last_i != b_last_i)) err_o <= 1'b1;
  end

  p_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_fire && add_en) |-> b_fire);
  p_no_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_en |-> !b_fire);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_fire && add_en && !a_data_i[DATA_W-1] && !b_data_i[DATA_W-1]) |=> !y_data_o[DATA_W-1]);
  p_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fire |=> (y_last_o == $past(a_last_i)));
endmodule

// File: tb/skip_relu_stage_tb_top.sv
`timescale 1ns/1ps
module skip_relu_stage_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic res_en = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic a_last = 0, a_valid = 0, b_last = 0, b_valid = 0, y_ready = 0;
  logic a_ready, b_ready, y_last, y_valid, err;
  logic [W-1:0] y_data;

  always #10 clk = ~clk;

  skip_relu_stage #(.DATA_W(W), .SHIFT(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .res_en_i(res_en),
    .a_data_i(a_data), .a_last_i(a_last), .a_valid_i(a_valid), .a_ready_o(a_ready),
    .b_data_i(b_data), .b_last_i(b_last), .b_valid_i(b_valid), .b_ready_o(b_ready),
    .y_data_o(y_data), .y_last_o(y_last), .y_valid_o(y_valid), .y_ready_i(y_ready),
    .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int la[64], lb[64];
  int exp_d[$];
  int exp_l[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int leaky(input int v);
    if (v >= 0) return v;
    return (v - 7) / 8;  // floor for negative v
  endfunction

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // run one layer of n elements; b_last marked at index blast
  task automatic run_layer(input bit m, input int n, input int blast);
    int ai = 0, bi = 0;
    bit started = 0, hold_pend = 0, lat_pend = 0;
    int hold_d = 0, hold_l = 0;
    while (ai < n || exp_d.size() > 0) begin
      @(negedge clk);
      a_valid = (ai < n) && ($urandom % 4 != 0);
      a_data  = la[ai < n ? ai : 0][W-1:0];
      a_last  = (ai == n - 1);
      b_valid = m ? ((bi < n) && ($urandom % 4 != 0)) : ($urandom % 2 == 0);
      b_data  = m ? lb[bi < n ? bi : 0][W-1:0] : W'($urandom);
      b_last  = m ? (bi == blast) : 1'b1;
      y_ready = ($urandom % 4 != 0);
      res_en  = started ? 1'($urandom) : m;
      #5;
      if (lat_pend) check(y_valid == 1'b1, "R10 output one cycle after accept", int'(y_valid), 1);
      lat_pend = 0;
      if (hold_pend) begin
        check(sx(y_data) == hold_d, "R9 data held under stall", sx(y_data), hold_d);
        check(int'(y_last) == hold_l, "R9 last held under stall", int'(y_last), hold_l);
      end
      hold_pend = 0;
      if (y_valid && y_ready) begin
        if (exp_d.size() == 0) check(1'b0, "R2/R3 unexpected output", sx(y_data), 0);
        else begin
          int ed, el;
          ed = exp_d.pop_front(); el = exp_l.pop_front();
          check(sx(y_data) == ed, m ? "R3 residual value" : "R2 pass value", sx(y_data), ed);
          check(int'(y_last) == el, "R6 last follows A", int'(y_last), el);
        end
      end else if (y_valid) begin
        check(a_ready == 1'b0, "R9 A stalled by back-pressure", int'(a_ready), 0);
        hold_pend = 1; hold_d = sx(y_data); hold_l = int'(y_last);
      end
      if (!m) check(b_ready == 1'b0, "R2 B not consumed in pass mode", int'(b_ready), 0);
      if (m && a_valid && !b_valid)
        check(a_ready == 1'b0, "R3 A waits for B", int'(a_ready), 0);
      if (a_valid && a_ready) begin
        if (m) check(b_valid && b_ready, "R3 B consumed with A", int'(b_ready), 1);
        exp_d.push_back(leaky(m ? sat8(la[ai] + lb[ai]) : la[ai]));
        exp_l.push_back(ai == n - 1);
        ai++;
        if (m) bi++;
        started = 1;
        lat_pend = 1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  task automatic fill_random(input int n, input int span);
    for (int i = 0; i < n; i++) begin
      la[i] = sx(W'($urandom % span)) ;
      lb[i] = sx(W'($urandom % span));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check(y_valid == 1'b0, "R1 y_valid after reset", int'(y_valid), 0);
    check(err == 1'b0, "R1 err after reset", int'(err), 0);

    // R4 R5 directed residual corners
    la[0] = 127;  lb[0] = 127;
    la[1] = -128; lb[1] = -128;
    la[2] = 100;  lb[2] = -3;
    la[3] = -1;   lb[3] = 0;
    la[4] = -9;   lb[4] = 0;
    la[5] = -100; lb[5] = 50;
    run_layer(1'b1, 6, 5);

    // R5 directed pass corners
    la[0] = -128; la[1] = -8; la[2] = 0; la[3] = 127; la[4] = -1; la[5] = -9;
    run_layer(1'b0, 6, 5);

    // R7 mode flips mid layer: random layers alternate modes
    for (int k = 0; k < 24; k++) begin
      int n;
      n = 1 + ($urandom % 20);
      fill_random(n, 256);
      run_layer(k[0], n, n - 1);
    end
    check(err == 1'b0, "R8 no error on matched layers", int'(err), 0);

    // R8 mismatched last flags
    fill_random(4, 256);
    run_layer(1'b1, 4, 1);
    @(negedge clk);
    check(err == 1'b1, "R8 mismatch sets error", int'(err), 1);

    fill_random(5, 256);
    run_layer(1'b0, 5, 4);
    fill_random(5, 256);
    run_layer(1'b1, 5, 4);
    check(err == 1'b1, "R8 error stays set", int'(err), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule